// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Post-Shifter

This block is the combinational execute stage of a small processor datapath. Two operands of parameterised width go through one of eight functions, picked by a 3-bit function code and a carry-in. The result, together with the carry, then passes through a post-shifter. A separate 3-bit code sets whether the shifter passes the value through, shifts it, rotates it through the carry bit, or replaces it with a constant.

All arithmetic uses one adder. The second adder input is the operand B, the inverted B, all ones, or zero, and the carry-in is added on top. This is why the carry-in chooses between pairs of related results: A-1 or A, A+B or A+B+1, A-B-1 or A-B, and A or A+1. Subtraction takes the two's complement of B as the inverted B plus a carry-in of 1.

The logic functions bypass the adder. The outputs are the shifted result, the final carry and a flag that marks an all-zero result. The block holds no state. Register reads, write-back and sequencing are left to the surrounding datapath.

Top module: `alu_shift_unit`

## Requirements
- R1: With cin=0, function codes 000, 001, 010 and 011 give A-1, A+B, A-B-1 and A, each modulo 2^W.
- R2: With cin=1, function codes 000, 001, 010 and 011 give A, A+B+1, A-B and A+1, each modulo 2^W.
- R3: For arithmetic codes the ALU carry is bit W of the full sum A + B' + cin, where B' is all ones (000), B (001), ~B (010) or zero (011).
- R4: Function codes 100, 101, 110 and 111 give NOT A, A XOR B, A AND B and A OR B. Their ALU carry is 0 and cin has no effect on them.
- R5: Shift code 000 passes the ALU result through. Code 001 shifts it left and code 010 shifts it right, with 0 entering in both cases. For all three codes the output carry equals the ALU carry.
- R6: Shift code 011 rotates left through the carry. The ALU carry enters bit 0, and the old MSB becomes the output carry.
- R7: Shift code 110 rotates right through the carry. The ALU carry enters the MSB, and the old bit 0 becomes the output carry.
- R8: Shift code 101 drives all ones, and codes 100 and 111 drive all zeros. For these codes the output carry equals the ALU carry.
- R9: The zero flag is 1 exactly when the final shifted result is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand |
| b | input | W | Second operand |
| fn_sel | input | 3 | Function code |
| cin | input | 1 | Carry-in to the adder |
| sh_sel | input | 3 | Post-shifter code |
| y | output | W | Final result |
| cout | output | 1 | Final carry |
| zero | output | 1 | Result-is-zero flag |

## Verification
The checker tests several properties on every input change:
- the constant fills and their zero flag,
- the 0 that enters on a plain shift,
- the cleared carry of the logic functions,
- the transfer and complement paths.

Only the bench's full sweep over both operands, every function code, both carry-in values and every shift code can show the exact sums, borrows and rotations. This includes how the ALU carry is threaded through the rotate codes.

// File: rtl/alu_shift_pkg.sv
package alu_shift_pkg;

  typedef enum logic [2:0] {
    FN_DEC_OR_PASS = 3'b000,
    FN_ADD         = 3'b001,
    FN_SUB         = 3'b010,
    FN_PASS_OR_INC = 3'b011,
    FN_NOT_A       = 3'b100,
    FN_XOR         = 3'b101,
    FN_AND         = 3'b110,
    FN_OR          = 3'b111
  } fn_code_e;

  typedef enum logic [2:0] {
    SH_NONE   = 3'b000,
    SH_LEFT   = 3'b001,
    SH_RIGHT  = 3'b010,
    SH_ROT_L  = 3'b011,
    SH_ZEROS  = 3'b100,
    SH_ONES   = 3'b101,
    SH_ROT_R  = 3'b110,
    SH_ZEROS2 = 3'b111
  } sh_code_e;

endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int W = 3
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   b_mode,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         carry
);
  localparam int SW = W + 1;

  logic [W-1:0]  b_eff;
  logic [SW-1:0] full;

  // Second adder input: all ones, B, inverted B, or zero
  always_comb begin
    case (b_mode)
      2'b00:   b_eff = '1;
      2'b01:   b_eff = b;
      2'b10:   b_eff = ~b;
      default: b_eff = '0;
    endcase
  end

  assign full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
  assign sum   = full[W-1:0];
  assign carry = full[W];
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 3
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   op,
  output logic [W-1:0] res
);
  // One bit slice per operand bit
  for (genvar i = 0; i < W; i++) begin : g_slice
    always_comb begin
      case (op)
        2'b00:   res[i] = ~a[i];
        2'b01:   res[i] = a[i] ^ b[i];
        2'b10:   res[i] = a[i] & b[i];
        default: res[i] = a[i] | b[i];
      endcase
    end
  end
endmodule

// File: rtl/alu_post_shift.sv
module alu_post_shift
  import alu_shift_pkg::*;
#(
  parameter int W = 3
) (
  input  logic [W-1:0] din,
  input  logic         cin,
  input  logic [2:0]   sel,
  output logic [W-1:0] dout,
  output logic         cout
);
  always_comb begin
    dout = din;
    cout = cin;
    case (sel)
      SH_NONE:  dout = din;
      SH_LEFT:  dout = {din[W-2:0], 1'b0};
      SH_RIGHT: dout = {1'b0, din[W-1:1]};
      SH_ROT_L: begin
        dout = {din[W-2:0], cin};
        cout = din[W-1];
      end
      SH_ROT_R: begin
        dout = {cin, din[W-1:1]};
        cout = din[0];
      end
      SH_ONES:  dout = '1;
      default:  dout = '0;
    endcase
  end
endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit #(
  parameter int W = 3
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   fn_sel,
  input  logic         cin,
  input  logic [2:0]   sh_sel,
  output logic [W-1:0] y,
  output logic         cout,
  output logic         zero
);
  logic [W-1:0] arith_res;
  logic         arith_c;
  logic [W-1:0] logic_res;
  logic [W-1:0] alu_res;
  logic         alu_c;

  alu_arith #(.W(W)) u_arith (
    .a(a), .b(b), .b_mode(fn_sel[1:0]), .cin(cin),
    .sum(arith_res), .carry(arith_c)
  );

  alu_logic #(.W(W)) u_logic (
    .a(a), .b(b), .op(fn_sel[1:0]), .res(logic_res)
  );

  always_comb begin
    if (fn_sel[2]) begin
      alu_res = logic_res;
      alu_c   = 1'b0;
    end else begin
      alu_res = arith_res;
      alu_c   = arith_c;
    end
  end

  alu_post_shift #(.W(W)) u_shift (
    .din(alu_res), .cin(alu_c), .sel(sh_sel),
    .dout(y), .cout(cout)
  );

  assign zero = (y == '0);
endmodule

// File: rtl/alu_shift_chk.sv
module alu_shift_chk #(
  parameter int W = 3
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [2:0]   fn_sel,
  input logic         cin,
  input logic [2:0]   sh_sel,
  input logic [W-1:0] y,
  input logic         cout,
  input logic         zero
);
  always_comb begin
    // R1
    transfer_chk: assert (!(fn_sel == 3'b011 && !cin && sh_sel == 3'b000) || y == a)
      else $error("transfer path mismatch");
    // R4
    logic_carry_chk: assert (!(fn_sel[2] && sh_sel == 3'b000) || !cout)
      else $error("logic op carry not cleared");
    // R4
    not_a_chk: assert (!(fn_sel == 3'b100 && sh_sel == 3'b000) || y == ~a)
      else $error("complement mismatch b=%0d", b);
    // R5
    shl_fill_chk: assert (sh_sel != 3'b001 || !y[0])
      else $error("left shift fill not zero");
    // R5
    shr_fill_chk: assert (sh_sel != 3'b010 || !y[W-1])
      else $error("right shift fill not zero");
    // R8
    ones_fill_chk: assert (sh_sel != 3'b101 || (y == '1 && !zero))
      else $error("ones fill wrong");
    // R8
    zeros_fill_chk: assert (!(sh_sel == 3'b100 || sh_sel == 3'b111) || (y == '0 && zero))
      else $error("zeros fill wrong");
  end
endmodule

bind alu_shift_unit alu_shift_chk #(.W(W)) u_chk (
  .a(a), .b(b), .fn_sel(fn_sel), .cin(cin), .sh_sel(sh_sel),
  .y(y), .cout(cout), .zero(zero)
);

// File: tb/sim_alu_shift_unit.sv
`timescale 1ns/1ps
module sim_alu_shift_unit;
  localparam int N = 3;
  localparam int MASK = (1 << N) - 1;

  logic clk;
  logic rst_n;
  logic [N-1:0] a, b;
  logic [2:0] fn_sel, sh_sel;
  logic cin;
  logic [N-1:0] y;
  logic cout, zero;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  alu_shift_unit #(.W(N)) u0 (
    .a(a), .b(b), .fn_sel(fn_sel), .cin(cin), .sh_sel(sh_sel),
    .y(y), .cout(cout), .zero(zero)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d f=%0d cin=%0d h=%0d actual=%0d expected=%0d",
               tag, a, b, fn_sel, cin, sh_sel, act, exp);
    end
  endtask

  initial begin
    rst_n = 0;
    a = '0; b = '0; fn_sel = '0; cin = 0; sh_sel = '0;
    repeat (2) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: A-1 of 0 wraps to all ones; R3: borrow leaves carry 0
    check("R1", int'(y), MASK);
    check("R3", int'(cout), 0);
    for (int ia = 0; ia <= MASK; ia++)
      for (int ib = 0; ib <= MASK; ib++)
        for (int f = 0; f < 8; f++)
          for (int c = 0; c < 2; c++)
            for (int h = 0; h < 8; h++) begin
              int bp, sum, r, rc, ey, ec;
              string tag;
              @(posedge clk);
              #1;
              a = N'(ia); b = N'(ib); fn_sel = 3'(f); cin = c[0]; sh_sel = 3'(h);
              // reference ALU
              if (f < 4) begin
                case (f)
                  0: bp = MASK;
                  1: bp = ib;
                  2: bp = (~ib) & MASK;
                  default: bp = 0;
                endcase
                sum = ia + bp + c;
                r = sum & MASK;
                rc = (sum >> N) & 1;
                tag = (c != 0) ? "R2" : "R1";
              end else begin
                case (f)
                  4: r = (~ia) & MASK;
                  5: r = ia ^ ib;
                  6: r = ia & ib;
                  default: r = ia | ib;
                endcase
                rc = 0;
                tag = "R4";
              end
              // reference shifter
              ec = rc;
              case (h)
                0: ey = r;
                1: begin ey = (r << 1) & MASK; tag = "R5"; end
                2: begin ey = r >> 1; tag = "R5"; end
                3: begin ey = ((r << 1) | rc) & MASK; ec = (r >> (N-1)) & 1; tag = "R6"; end
                6: begin ey = (rc << (N-1)) | (r >> 1); ec = r & 1; tag = "R7"; end
                5: begin ey = MASK; tag = "R8"; end
                default: begin ey = 0; tag = "R8"; end
              endcase
              @(negedge clk);
              check(tag, int'(y), ey);
              if (f < 4 && h == 0) check("R3", int'(cout), ec);
              else check(tag, int'(cout), ec);
              check("R9", int'(zero), (ey == 0) ? 1 : 0);
            end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule